// File: doc/BRIEF.md
# Infrared Pulse Codec for a UART Serial Line

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side it turns every bit cell of the UART output into an infrared line state. A zero bit becomes one short active-high pulse, 3/16 of a bit wide and centred in the cell. A one bit leaves the infrared output low. All timing is taken from a one-cycle tick that the baud generator issues sixteen times per bit.

On the receive side, a pulse arriving on the infrared input is synchronised into the clock domain and detected on its rising edge. It is then widened into a low level on the UART receive line that lasts one full bit time (sixteen ticks). Further edges during that window are ignored. A single enable input selects infrared operation. With it clear, the UART uses its plain serial pins. The codec drives its infrared output low and holds its UART receive output at the idle-high level.

Top module: `ir_codec`

## Requirements
- R1: While reset is asserted, `ir_tx_o` is 0 and `uart_rxd_o` is 1. All tick counters start from zero when reset is released.
- R2: When `uart_txd_i` is 0 for a bit cell, `ir_tx_o` is 1 for exactly three ticks, after the ticks with index 7, 8 and 9 of the cell (counted from 0). It is 0 after every other tick of the cell.
- R3: When `uart_txd_i` is 1 for a bit cell, `ir_tx_o` stays 0 for the whole cell.
- R4: The cell index restarts at 0 on the tick that sees `uart_txd_i` change value, and wraps from 15 to 0 otherwise. Consecutive zero bits therefore each give their own separate pulse.
- R5: A rising edge on `ir_rx_i` (active high) that is accepted drives `uart_rxd_o` to 0. It returns to 1 on the sixteenth tick after the edge was taken.
- R6: A rising edge on `ir_rx_i` while `uart_rxd_o` is low, and before its final tick, has no effect. The low level ends on its original schedule and does not restart.
- R7: An edge taken in the same cycle as the final tick of a low window is accepted. `uart_rxd_o` stays 0 and a new sixteen-tick window begins.
- R8: With `ir_en_i` at 0, `ir_tx_o` is 0 and `uart_rxd_o` is 1 from the next clock on, whatever the inputs are. Clearing the enable in the middle of a pulse or a window ends it.
- R9: While enabled, `ir_tx_o` changes only on clock edges where `tick16_i` is 1.
- R10: A rise on `ir_rx_i` set up before clock edge A is taken at edge A+2, two synchroniser stages plus one edge register. `uart_rxd_o` is low after edge A+2 and still high after edges A and A+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse, sixteen per bit time |
| ir_en_i | input | 1 | Infrared mode enable |
| uart_txd_i | input | 1 | Serial stream from the UART transmitter |
| uart_rxd_o | output | 1 | Decoded serial stream to the UART receiver, idle high |
| ir_tx_o | output | 1 | Pulse output to the infrared emitter, active high |
| ir_rx_i | input | 1 | Pulse input from the infrared detector, active high |

## Verification
The delicate collision is a new received edge that lands in the very cycle whose tick closes the current low window. Expiry and acceptance then compete for the counter and the receive output. The bench provokes this by placing a rise on the infrared input exactly two clocks before the sixteenth tick. It then requires the receive line to stay low across that tick and for fifteen further ticks, and to rise on the sixteenth. A second case places an edge in mid-window and requires that it leaves the end of the window untouched.

// File: rtl/ir_codec_pkg.sv
package ir_codec_pkg;

  // True when a cell index lies in the pulse window [start, start+len)
  function automatic logic in_window(input int unsigned phase,
                                     input int unsigned start,
                                     input int unsigned len);
    return (phase >= start) && (phase < start + len);
  endfunction

  // Cell index that follows cur, wrapping at ovs
  function automatic int unsigned next_phase(input int unsigned cur,
                                             input int unsigned ovs);
    return (cur + 1 >= ovs) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/ir_sync_chain.sv
module ir_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ir_pulse_enc.sv
module ir_pulse_enc
  import ir_codec_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned PSTART = 7,
  parameter int unsigned PLEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic txd_i,
  output logic ir_tx_o
);
  localparam int unsigned PW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] PHASE_AFTER_START = PW'(next_phase(PSTART, OVS));

  logic [PW-1:0] phase_q, cur_phase;
  logic          prev_q, edge_evt, pulse_d, pulse_q;

  // A change of the serial level marks the start of a new bit cell
  always_comb begin
    edge_evt  = txd_i ^ prev_q;
    cur_phase = edge_evt ? '0 : phase_q;
    pulse_d   = !txd_i && in_window(32'(cur_phase), PSTART, PLEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      phase_q <= '0;
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else if (tick_i) begin
      phase_q <= PW'(next_phase(32'(cur_phase), OVS));
      prev_q  <= txd_i;
      pulse_q <= pulse_d;
    end
  end

  assign ir_tx_o = pulse_q;

  // R2: a pulse begins only on the tick of the first window index
  p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> (phase_q == PHASE_AFTER_START));

  // R3: the pulse is present only while the last sampled bit was zero
  p_pulse_zero_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !prev_q);

  // R9: output moves only on tick edges while enabled
  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(pulse_q));
endmodule

// File: rtl/ir_pulse_dec.sv
module ir_pulse_dec #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic ir_rx_i,
  output logic rxd_o
);
  localparam int unsigned CW = $clog2(OVS + 1);
  localparam logic [CW-1:0] STRETCH = CW'(OVS);

  logic          sync_q, prev_q, rise_evt, final_tick, accept;
  logic [CW-1:0] rx_cnt;
  logic          rxd_q;

  ir_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ir_rx_i),
    .q_o   (sync_q)
  );

  // Edge is accepted when idle, or in the cycle the window expires
  always_comb begin
    rise_evt   = sync_q && !prev_q;
    final_tick = tick_i && (rx_cnt == CW'(1));
    accept     = en_i && rise_evt && ((rx_cnt == '0) || final_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rx_cnt <= '0;
      rxd_q  <= 1'b1;
    end else begin
      prev_q <= sync_q;
      if (!en_i) begin
        rx_cnt <= '0;
        rxd_q  <= 1'b1;
      end else if (accept) begin
        rx_cnt <= STRETCH;
        rxd_q  <= 1'b0;
      end else if (tick_i && (rx_cnt != '0)) begin
        rx_cnt <= rx_cnt - CW'(1);
        if (rx_cnt == CW'(1)) rxd_q <= 1'b1;
      end
    end
  end

  assign rxd_o = rxd_q;

  // R5: low level and a running window always go together
  p_low_has_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_q |-> (rx_cnt != '0));
  p_high_no_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_q |-> (rx_cnt == '0));

  // R6: a mid-window edge never lengthens the window
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && rx_cnt > CW'(1)) |=> (rx_cnt <= $past(rx_cnt)));

  // R7: edge on the closing tick starts a fresh window
  p_restart_on_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rise_evt && tick_i && rx_cnt == CW'(1)) |=> (rx_cnt == STRETCH && !rxd_q));
endmodule

// File: rtl/ir_codec.sv
module ir_codec #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned PSTART      = 7,
  parameter int unsigned PLEN        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16_i,
  input  logic ir_en_i,
  input  logic uart_txd_i,
  output logic uart_rxd_o,
  output logic ir_tx_o,
  input  logic ir_rx_i
);
  ir_pulse_enc #(.OVS(OVS), .PSTART(PSTART), .PLEN(PLEN)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (ir_en_i),
    .tick_i  (tick16_i),
    .txd_i   (uart_txd_i),
    .ir_tx_o (ir_tx_o)
  );

  ir_pulse_dec #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (ir_en_i),
    .tick_i  (tick16_i),
    .ir_rx_i (ir_rx_i),
    .rxd_o   (uart_rxd_o)
  );

  // R8: disabled codec presents idle levels on both outputs
  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en_i |=> (!ir_tx_o && uart_rxd_o));
endmodule

// File: tb/ir_codec_tb_top.sv
module ir_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OVS    = 16;
  localparam int PSTART = 7;
  localparam int PLEN   = 3;
  localparam int NVEC   = 5;
  localparam int NBITS  = 10;

  // Serial patterns, sent LSB first, and the number of zero bits in each
  localparam logic [NBITS-1:0] VEC_BITS [NVEC] = '{
    10'b1111111110, 10'b1000000000, 10'b1010101010, 10'b1100110010, 10'b1001011000
  };
  localparam int VEC_ZEROS [NVEC] = '{1, 9, 5, 5, 6};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tick = 1'b0;
  logic ir_en = 1'b0;
  logic txd = 1'b1;
  logic ir_rx = 1'b0;
  logic rxd, irtx;

  int n_checks = 0;
  int n_fail = 0;
  int between = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_codec dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16_i   (tick),
    .ir_en_i    (ir_en),
    .uart_txd_i (txd),
    .uart_rxd_o (rxd),
    .ir_tx_o    (irtx),
    .ir_rx_i    (ir_rx)
  );

  function automatic logic [OVS-1:0] exp_mask(input logic b);
    logic [OVS-1:0] m;
    m = '0;
    if (b == 1'b0)
      for (int j = PSTART; j < PSTART + PLEN; j++) m[j] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, return at the next falling edge
  task automatic cyc(input logic t);
    tick = t;
    @(negedge clk);
  endtask

  task automatic tk();
    cyc(1'b0); cyc(1'b0); cyc(1'b0); cyc(1'b1);
  endtask

  task automatic tk_obs();
    logic v0;
    v0 = irtx;
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0);
      if (irtx !== v0) between++;
    end
    cyc(1'b1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [OVS-1:0] seen;
    logic last, bv;
    int pulses;

    #2 rst_n = 1'b0;
    ir_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ir_tx in reset", 32'(irtx), 0);
    check("R1 rxd in reset", 32'(rxd), 1);
    rst_n = 1'b1;
    repeat (3) tk();

    // Vector walk through the encoder: R2, R3, R4, R9
    for (int v = 0; v < NVEC; v++) begin
      pulses = 0;
      between = 0;
      last = irtx;
      for (int b = 0; b < NBITS; b++) begin
        bv = VEC_BITS[v][b];
        txd = bv;
        seen = '0;
        for (int j = 0; j < OVS; j++) begin
          tk_obs();
          seen[j] = irtx;
          if (irtx && !last) pulses++;
          last = irtx;
        end
        check(bv ? "R3 one-bit cell" : "R2 zero-bit cell", 32'(seen), 32'(exp_mask(bv)));
      end
      check("R4 pulses per pattern", pulses, VEC_ZEROS[v]);
      check("R9 change between ticks", between, 0);
    end
    txd = 1'b1;
    repeat (2) tk();

    // R10: decoder latency through synchroniser and edge register
    ir_rx = 1'b1;
    cyc(1'b0); check("R10 after edge A", 32'(rxd), 1);
    cyc(1'b0); check("R10 after edge A+1", 32'(rxd), 1);
    cyc(1'b0); check("R10 after edge A+2", 32'(rxd), 0);
    cyc(1'b1);
    ir_rx = 1'b0;
    // R5: sixteen-tick window
    repeat (14) tk();
    check("R5 low after 15 ticks", 32'(rxd), 0);
    tk();
    check("R5 high after 16 ticks", 32'(rxd), 1);

    // R6: mid-window edge ignored
    repeat (2) tk();
    ir_rx = 1'b1; tk(); ir_rx = 1'b0;
    repeat (6) tk();
    ir_rx = 1'b1; tk(); ir_rx = 1'b0;
    repeat (7) tk();
    check("R6 low before close", 32'(rxd), 0);
    tk();
    check("R6 closes on schedule", 32'(rxd), 1);
    repeat (4) tk();
    check("R6 no late restart", 32'(rxd), 1);

    // R7: edge coinciding with the closing tick
    ir_rx = 1'b1; tk(); ir_rx = 1'b0;
    repeat (14) tk();
    check("R7 low before close", 32'(rxd), 0);
    ir_rx = 1'b1;
    cyc(1'b0); cyc(1'b0); cyc(1'b1);
    ir_rx = 1'b0;
    check("R7 stays low on close", 32'(rxd), 0);
    repeat (15) tk();
    check("R7 new window still low", 32'(rxd), 0);
    tk();
    check("R7 new window ends", 32'(rxd), 1);

    // R8: disabled codec
    ir_en = 1'b0;
    ir_rx = 1'b1; tk(); ir_rx = 1'b0;
    check("R8 rxd idle when off", 32'(rxd), 1);
    repeat (3) tk();
    check("R8 rxd idle later", 32'(rxd), 1);
    txd = 1'b0;
    seen = '0;
    for (int j = 0; j < OVS; j++) begin
      tk_obs();
      seen[j] = irtx;
    end
    check("R8 no pulse when off", 32'(seen), 0);
    txd = 1'b1;

    // R8: disabling mid-window
    ir_en = 1'b1;
    tk();
    ir_rx = 1'b1; tk(); ir_rx = 1'b0;
    repeat (3) tk();
    check("R5 window running", 32'(rxd), 0);
    ir_en = 1'b0;
    cyc(1'b0);
    check("R8 window cut by disable", 32'(rxd), 1);

    // R8: disabling mid-pulse
    ir_en = 1'b1;
    tk();
    txd = 1'b0;
    repeat (PSTART + 1) tk();
    check("R2 pulse at index 7", 32'(irtx), 1);
    ir_en = 1'b0;
    cyc(1'b0);
    check("R8 pulse cut by disable", 32'(irtx), 0);

    summary();
    $finish;
  end
endmodule